// File: doc/BRIEF.md
# SPI Slave Host Control Port with Flow Control

This block connects an external host controller to the chip over a four-wire SPI link. The host writes 32-bit command words. Each word arrives as four 8-bit bytes, most significant bit first, in SPI mode 0. The port collects these words into a receive FIFO, and the internal logic drains that FIFO through a ready/valid word interface. In the other direction, internal logic queues message words into a transmit FIFO. The port shifts the oldest queued word out on MISO while the host clocks in its next command.

Two sideband outputs help the host pace its traffic:

- **Busy** (`busy_o`) tells the host to stop sending while the receive FIFO is close to full.
- **Interrupt** (`irq_o`) stays high while at least one message word is waiting in the transmit FIFO.

A mode strap is captured once, just after reset is released. It selects either the SPI slave function or a disabled state that stands in for the modes not built here.

All SPI pins are oversampled in the system clock domain through synchronisers. SCLK must therefore run well below the system clock. With the default two synchroniser stages, each SCLK high phase and each SCLK low phase must last at least four system clock cycles. MISO is split into a data bit and a drive enable, so that the pad ring can build the tristate buffer.

Top module: `host_ctl_port`

## Requirements
- R1: `mode_i` is sampled on the first rising clock edge after `rst_ni` goes high. Value 1 selects SPI slave and 0 selects disabled. Later changes of `mode_i` have no effect until the next reset.
- R2: In slave mode, MOSI is sampled on rising SCLK edges while `spi_cs_ni` is low. Every 32 bits, taken most significant bit first, form one word. Words appear on `rx_data_o`/`rx_valid_o` in arrival order and are removed when `rx_ready_i` is high.
- R3: The head word of the transmit FIFO is shifted out on `spi_miso_o`, most significant bit first. Each bit is valid before the rising SCLK edge that samples it, and the next bit is presented after the following falling edge.
- R4: `busy_o` is high while the receive FIFO holds at least `FIFO_DEPTH - BUSY_MARGIN` words, and low below that level. A word that completes while the receive FIFO is full is dropped.
- R5: `irq_o` is high while the transmit FIFO is non-empty. A transmit word is removed only when its 32nd bit has been clocked, so `irq_o` falls after the last waiting word has been fully read.
- R6: A word read while the transmit FIFO is empty returns all ones (0xFFFFFFFF).
- R7: Raising `spi_cs_ni` partway through a word discards the partial receive word. The transmit word then being shifted is not consumed and is sent again in the next transfer.
- R8: `spi_miso_oe_o` is high only while `spi_cs_ni` is low in slave mode.
- R9: In disabled mode, `busy_o` stays high, `irq_o` and `spi_miso_oe_o` stay low, and SPI traffic produces no receive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode strap: 1 = SPI slave, 0 = disabled |
| spi_sclk_i | input | 1 | SPI serial clock from the host |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from the host |
| spi_miso_o | output | 1 | SPI data to the host |
| spi_miso_oe_o | output | 1 | Drive enable for the MISO pad |
| busy_o | output | 1 | Flow control: host must hold off |
| irq_o | output | 1 | A message word is waiting |
| rx_data_o | output | WORD_W | Received command word |
| rx_valid_o | output | 1 | `rx_data_o` is valid |
| rx_ready_i | input | 1 | Internal consumer takes the word |
| tx_data_i | input | WORD_W | Message word to queue |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| tx_ready_o | output | 1 | Transmit FIFO can accept a word |

## Verification
The assertions check on every cycle that:

- the latched mode never changes after capture;
- busy is high whenever the receive FIFO is full;
- the interrupt only falls on the cycle after a transmit pop;
- the bit counter returns to zero whenever chip select is inactive;
- neither FIFO is written when full or read when empty;
- the disabled mode keeps its outputs quiet.

Some properties only the bench scenarios can show. These are the word and bit ordering on MOSI and MISO, the all-ones fill, dropping of an overflow word, and discard-and-resend after an aborted transfer. The same holds for the exact occupancy at which busy sets and clears, and for the strap being ignored after reset.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  typedef enum logic {
    MODE_OFF   = 1'b0,
    MODE_SLAVE = 1'b1
  } hcp_mode_e;
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int unsigned    WIDTH   = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/hcp_fifo.sv
module hcp_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({wr_en_i, rd_en_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign cnt_o     = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o); // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R4
endmodule

// File: rtl/hcp_spi_engine.sv
module hcp_spi_engine #(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BC_W       = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] tx_head_i,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              miso_o
);
  logic [2:0]        pins_s;
  logic              sclk_s, cs_s, mosi_s;
  logic              sclk_d_q, cs_d_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic [WORD_W-1:0] rx_sh_q, tx_sh_q;
  logic              reload_q, from_fifo_q;
  logic              active, rise, fall, cs_fall, last, word_start;

  hcp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, mosi_i}),
    .q_o    (pins_s)
  );
  assign {sclk_s, cs_s, mosi_s} = pins_s;

  assign active     = en_i && !cs_s;
  assign rise       = active && sclk_s && !sclk_d_q;
  assign fall       = active && !sclk_s && sclk_d_q;
  assign cs_fall    = active && cs_d_q;
  assign last       = (bit_cnt_q == BC_W'(WORD_W - 1));
  assign word_start = cs_fall || (fall && reload_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q    <= 1'b0;
      cs_d_q      <= 1'b1;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '1;
      reload_q    <= 1'b0;
      from_fifo_q <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_s;
      if (!active) begin
        bit_cnt_q   <= '0;
        reload_q    <= 1'b0;
        from_fifo_q <= 1'b0;
      end
      if (word_start) begin
        tx_sh_q     <= tx_empty_i ? '1 : tx_head_i;
        from_fifo_q <= !tx_empty_i;
        reload_q    <= 1'b0;
      end else if (fall) begin
        tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b1};
      end
      if (rise) begin
        rx_sh_q   <= {rx_sh_q[WORD_W-2:0], mosi_s};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (last) begin
          reload_q    <= 1'b1;
          from_fifo_q <= 1'b0;
        end
      end
    end
  end

  assign rx_word_o = {rx_sh_q[WORD_W-2:0], mosi_s};
  assign rx_push_o = rise && last && !rx_full_i;
  assign tx_pop_o  = rise && last && from_fifo_q;
  assign miso_o    = tx_sh_q[WORD_W-1];

  AST_BITCNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (bit_cnt_q == '0)); // R7
  AST_PUSH_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_o || tx_pop_o) |-> (en_i && !cs_s)); // R9
endmodule

// File: rtl/host_ctl_port.sv
module host_ctl_port
  import hcp_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned BUSY_MARGIN = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  localparam logic [CW-1:0] BUSY_LVL = CW'(FIFO_DEPTH - BUSY_MARGIN);

  hcp_mode_e         mode_q;
  logic              armed_q, slave;
  logic              rx_push, rx_empty, rx_full, rx_pop;
  logic [WORD_W-1:0] rx_word;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic              tx_pop, tx_empty, tx_full, tx_push;
  logic [WORD_W-1:0] tx_head;

  // strap captured once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      mode_q  <= hcp_mode_e'(mode_i);
      armed_q <= 1'b1;
    end
  end
  assign slave = (mode_q == MODE_SLAVE);

  hcp_spi_engine #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (slave),
    .sclk_i     (spi_sclk_i),
    .cs_ni      (spi_cs_ni),
    .mosi_i     (spi_mosi_i),
    .tx_head_i  (tx_head),
    .tx_empty_i (tx_empty),
    .rx_full_i  (rx_full),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_word_o  (rx_word),
    .miso_o     (spi_miso_o)
  );

  assign rx_pop = rx_ready_i && !rx_empty;

  hcp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rx_push),
    .wr_data_i (rx_word),
    .rd_en_i   (rx_pop),
    .rd_data_o (rx_data_o),
    .empty_o   (rx_empty),
    .full_o    (rx_full),
    .cnt_o     (rx_cnt)
  );

  assign tx_push = tx_valid_i && !tx_full;

  hcp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (tx_push),
    .wr_data_i (tx_data_i),
    .rd_en_i   (tx_pop),
    .rd_data_o (tx_head),
    .empty_o   (tx_empty),
    .full_o    (tx_full),
    .cnt_o     (tx_cnt)
  );

  assign rx_valid_o    = !rx_empty;
  assign tx_ready_o    = !tx_full;
  assign busy_o        = !slave || (rx_cnt >= BUSY_LVL);
  assign irq_o         = slave && !tx_empty;
  assign spi_miso_oe_o = slave && !spi_cs_ni;

  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(mode_q)); // R1
  AST_BUSY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full |-> busy_o); // R4
  AST_IRQ_DROP_ON_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(tx_pop)); // R5
  AST_TX_CNT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave && tx_cnt != '0) |-> irq_o); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !slave) |-> (busy_o && !irq_o && !spi_miso_oe_o && !rx_push)); // R9
  AST_OE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_ni |-> !spi_miso_oe_o); // R8
endmodule

// File: tb/host_ctl_port_test.sv
module host_ctl_port_test;
  localparam int W     = 32;
  localparam int DEPTH = 4;
  localparam int MARG  = 1;
  localparam int HALF  = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b1;
  logic         sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic         miso, miso_oe, busy, irq;
  logic [W-1:0] rx_data, tx_data = '0;
  logic         rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  host_ctl_port #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .BUSY_MARGIN(MARG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .spi_sclk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .busy_o(busy), .irq_o(irq),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_ni = 1'b0; mode_i = m; cs_n = 1'b1; sclk = 1'b0;
    clks(3);
    rst_ni = 1'b1;
    clks(2);
    mode_i = ~m;
    clks(2);
  endtask

  // clocks nbits bits in the current select window; returns MISO bits
  task automatic shift_bits(input logic [W-1:0] out, input int nbits, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = out[W-1-i];
      clks(HALF);
      got = {got[W-2:0], miso};
      sclk = 1'b1;
      clks(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [W-1:0] out, output logic [W-1:0] got);
    cs_n = 1'b0;
    clks(8);
    shift_bits(out, W, got);
    clks(HALF);
    cs_n = 1'b1;
    clks(8);
  endtask

  task automatic push_tx(input logic [W-1:0] d);
    tx_data = d; tx_valid = 1'b1;
    clks(1);
    tx_valid = 1'b0;
    clks(1);
  endtask

  task automatic pop_rx(input logic [W-1:0] exp, input string req);
    chk(rx_valid === 1'b1, req, {31'd0, rx_valid}, 32'd1);
    chk(rx_data === exp, req, rx_data, exp);
    rx_ready = 1'b1;
    clks(1);
    rx_ready = 1'b0;
    clks(1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] got;
    logic [W-1:0] pat [5];
    pat[0] = 32'h1234_5678; pat[1] = 32'hA5A5_0F0F; pat[2] = 32'h8000_0001;
    pat[3] = 32'hFFFF_0000; pat[4] = 32'hDEAD_BEEF;

    do_reset(1'b1);
    // reset state, strap changed to 0 after capture (R1)
    chk(busy === 1'b0, "R1 busy after reset", {31'd0, busy}, 32'd0);
    chk(irq === 1'b0, "R5 irq after reset", {31'd0, irq}, 32'd0);
    chk(miso_oe === 1'b0, "R8 oe idle", {31'd0, miso_oe}, 32'd0);
    chk(rx_valid === 1'b0, "R2 rx empty", {31'd0, rx_valid}, 32'd0);
    chk(tx_ready === 1'b1, "R5 tx ready", {31'd0, tx_ready}, 32'd1);

    // R6 empty tx returns ones; R8 oe during select
    cs_n = 1'b0;
    clks(2);
    chk(miso_oe === 1'b1, "R8 oe selected", {31'd0, miso_oe}, 32'd1);
    cs_n = 1'b1;
    clks(8);
    xfer(pat[0], got);
    chk(got === 32'hFFFF_FFFF, "R6 empty read", got, 32'hFFFF_FFFF);
    pop_rx(pat[0], "R2 single word");

    // R4 fill receive FIFO, threshold DEPTH-MARG = 3
    for (int k = 0; k < 5; k++) begin
      xfer(pat[k], got);
      if (k + 1 < DEPTH - MARG)
        chk(busy === 1'b0, "R4 busy below level", {31'd0, busy}, 32'd0);
      else
        chk(busy === 1'b1, "R4 busy at level", {31'd0, busy}, 32'd1);
    end
    for (int k = 0; k < DEPTH; k++) begin
      pop_rx(pat[k], "R2 order / R4 drop");
      chk(busy === ((DEPTH - 1 - k) >= (DEPTH - MARG)), "R4 busy release",
          {31'd0, busy}, {31'd0, ((DEPTH - 1 - k) >= (DEPTH - MARG))});
    end
    chk(rx_valid === 1'b0, "R4 overflow word dropped", {31'd0, rx_valid}, 32'd0);

    // R3/R5 message words out on MISO
    push_tx(32'hC001_D00D); push_tx(32'h0000_0001); push_tx(32'h7F00_00FE);
    chk(irq === 1'b1, "R5 irq set", {31'd0, irq}, 32'd1);
    xfer(32'h1111_1111, got);
    chk(got === 32'hC001_D00D, "R3 msg0", got, 32'hC001_D00D);
    xfer(32'h2222_2222, got);
    chk(got === 32'h0000_0001, "R3 msg1", got, 32'h0000_0001);
    chk(irq === 1'b1, "R5 irq held", {31'd0, irq}, 32'd1);
    xfer(32'h3333_3333, got);
    chk(got === 32'h7F00_00FE, "R3 msg2", got, 32'h7F00_00FE);
    chk(irq === 1'b0, "R5 irq dropped", {31'd0, irq}, 32'd0);
    xfer(32'h4444_4444, got);
    chk(got === 32'hFFFF_FFFF, "R6 after drain", got, 32'hFFFF_FFFF);
    pop_rx(32'h1111_1111, "R2 msg rx0"); pop_rx(32'h2222_2222, "R2 msg rx1");
    pop_rx(32'h3333_3333, "R2 msg rx2"); pop_rx(32'h4444_4444, "R2 msg rx3");

    // R7 abort mid-word
    push_tx(32'h5A5A_C3C3);
    cs_n = 1'b0;
    clks(8);
    shift_bits(32'hFFFF_FFFF, 13, got);
    clks(HALF);
    cs_n = 1'b1;
    clks(8);
    chk(rx_valid === 1'b0, "R7 partial discarded", {31'd0, rx_valid}, 32'd0);
    chk(irq === 1'b1, "R7 tx kept", {31'd0, irq}, 32'd1);
    xfer(32'h0BAD_F00D, got);
    chk(got === 32'h5A5A_C3C3, "R7 tx resent", got, 32'h5A5A_C3C3);
    pop_rx(32'h0BAD_F00D, "R7 clean word");
    chk(rx_valid === 1'b0, "R7 single word", {31'd0, rx_valid}, 32'd0);

    // R9 disabled mode; R1 strap flips to 1 after capture
    do_reset(1'b0);
    chk(busy === 1'b1, "R9 busy disabled", {31'd0, busy}, 32'd1);
    push_tx(32'h1357_9BDF);
    chk(irq === 1'b0, "R9 irq disabled", {31'd0, irq}, 32'd0);
    cs_n = 1'b0;
    clks(2);
    chk(miso_oe === 1'b0, "R9 oe disabled", {31'd0, miso_oe}, 32'd0);
    cs_n = 1'b1;
    clks(4);
    xfer(32'h2468_ACE0, got);
    chk(rx_valid === 1'b0, "R1 R9 no rx when disabled", {31'd0, rx_valid}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule